// File: doc/BRIEF.md
# Burst SPI Transmitter with Aligned Clock Generator

This block drives a burst of bytes onto an SPI bus, either one bit per clock on a single data lane or one nibble per clock on four lanes. Bytes arrive on a valid/ready stream. A start strobe launches a burst of a given number of data cycles. The data shifter and the SPI clock pulse generator are two separate engines. Both are reset on every start. The clock generator is released only after a programmable phase delay, so its first edge lands in a known relation to the data path.

The SPI clock period is 2, 4, 6 or 8 system clocks, selected by a two-bit code, and the high time is always half the period. Data lanes change only when the clock falls and stay steady for the whole high phase. If the byte stream runs dry in the middle of a burst, the clock is held low until the next byte arrives, so no stale data is ever clocked out. A one-cycle done pulse marks the end of the burst.

Top module: `spi_burst_tx`

## Requirements
- R1: With `div_sel_i` = k (0..3), every SPI clock high phase lasts exactly k+1 system clocks, and when data is available the low phase lasts k+1 system clocks as well (period 2k+2).
- R2: A burst started with `cycles_i` = N produces exactly N rising edges on `sck_o`. After the falling edge of the last pulse, `done_o` is high for exactly one cycle and `sck_o` stays low.
- R3: With `quad_i` = 0, each data cycle carries one bit on `sd_o[0]`, most-significant bit of each byte first, and `sd_o[3:1]` stays 0.
- R4: With `quad_i` = 1, each data cycle carries one nibble on `sd_o[3:0]` (bit 3 = nibble MSB), high nibble of each byte first, so N bytes take 2N cycles. An odd cycle count sends only the high nibble of the last byte.
- R5: Counting system clock edges from the one that captures `start_i` as edge 0, and with data already offered, `sck_o` is first high after edge max(`phase_i`,2)+k+1.
- R6: Each start resets the clock generator, so the R5 timing holds for every burst whatever the divider and state of the previous burst.
- R7: `sd_o` changes only while `sck_o` is low and is stable throughout every high phase.
- R8: If no byte is available when a data cycle needs one, `sck_o` stays low until a byte arrives. The byte sequence and the high time are unaffected.
- R9: `ready_o` is high only during a burst that still needs bytes. A burst consumes exactly ceil(N/8) bytes (single lane) or ceil(N/2) bytes (quad), and `ready_o` is 0 when idle.
- R10: `start_i` is ignored while a burst is in progress and when `cycles_i` is 0.
- R11: After reset, `sck_o`, `sd_o`, `done_o` and `ready_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a burst (sampled when idle) |
| quad_i | input | 1 | 1: four data lanes, 0: single lane |
| div_sel_i | input | DIV_W | SPI clock period select, period = 2*(code+1) |
| phase_i | input | PH_W | Delay from data path start to clock release, minimum 2 |
| cycles_i | input | CNT_W | Burst length in data cycles |
| data_i | input | 8 | Stream byte |
| valid_i | input | 1 | Stream byte valid |
| ready_o | output | 1 | Stream byte accepted when high with valid_i |
| sck_o | output | 1 | SPI clock, registered |
| sd_o | output | 4 | SPI data lanes, registered |
| done_o | output | 1 | One-cycle pulse at burst end |

## Verification
The assertions assume that `valid_i` and `data_i` are stable between system clock edges, and that the mode, divider, phase and count inputs are meaningful only in the cycle that `start_i` is accepted. The bench drives every input just after the falling system clock edge and changes a presented byte only after it has been accepted. The rise-with-data and stable-while-high properties also assume that the stream never offers more bytes than the burst asks for. The bench keeps surplus bytes queued but relies on `ready_o` to hold them back. Stall stimulus holds `valid_i` low for several cycles between bytes. This covers the paused-clock path without breaking the handshake.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN
  } ctrl_state_e;
endpackage

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PH_W  = 4,
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             quad_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             fin_i,
  output logic             restart_o,
  output logic             busy_o,
  output logic             run_o,
  output logic             done_o,
  output logic             quad_o,
  output logic [DIV_W-1:0] div_sel_o
);
  ctrl_state_e     state_q;
  logic [PH_W-1:0] lead_q;
  logic [PH_W-1:0] lead_eff;
  logic            go;
  logic            done_q;
  logic            quad_q;
  logic [DIV_W-1:0] div_q;

  assign go       = (state_q == ST_IDLE) && start_i && (|cycles_i);
  assign lead_eff = (phase_i < PH_W'(2)) ? PH_W'(2) : phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lead_q  <= '0;
      done_q  <= 1'b0;
      quad_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_LEAD;
          lead_q  <= lead_eff;
          quad_q  <= quad_i;
          div_q   <= div_sel_i;
        end
        ST_LEAD: begin
          if (lead_q == PH_W'(1)) state_q <= ST_RUN;
          else                    lead_q  <= lead_q - PH_W'(1);
        end
        ST_RUN: if (fin_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign restart_o = go;
  assign busy_o    = (state_q != ST_IDLE);
  assign run_o     = (state_q == ST_RUN);
  assign done_o    = done_q;
  assign quad_o    = quad_q;
  assign div_sel_o = div_q;

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_lead_before_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(state_q == ST_LEAD));
endmodule

// File: rtl/spi_burst_clkgen.sv
module spi_burst_clkgen #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             unit_ok_i,
  output logic             sck_o,
  output logic             take_o,
  output logic             fin_o
);
  localparam int unsigned CW = DIV_W + 2;

  logic [CW-1:0]    cnt_q, cnt_nxt, half_w, last_w;
  logic [CNT_W-1:0] left_q;
  logic             sck_q;
  logic             hold, adv, wrap;

  assign half_w  = CW'(div_sel_i) + CW'(1);
  assign last_w  = (half_w << 1) - CW'(1);
  // pause only at the start of a low phase, never inside a pulse
  assign hold    = (cnt_q == '0) && !unit_ok_i;
  assign adv     = en_i && !hold && (left_q != '0);
  assign wrap    = adv && (cnt_q == last_w);
  assign cnt_nxt = wrap ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      left_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      left_q <= cycles_i;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
      sck_q <= (cnt_nxt >= half_w);
      if (wrap) left_q <= left_q - CNT_W'(1);
    end
  end

  assign sck_o  = sck_q;
  assign take_o = wrap;
  assign fin_o  = wrap && (left_q == CNT_W'(1));

  assert_sck_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sck_q);

  assert_rise_has_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_q) |-> unit_ok_i);

  assert_take_in_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> sck_q);
endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              init_quad_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic              busy_i,
  input  logic              quad_i,
  input  logic              take_i,
  input  logic              sck_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic [LANES-1:0]  sd_o,
  output logic              unit_ok_o
);
  logic [BYTE_W-1:0] cur_q, buf_q, src_w, src_shift;
  logic [3:0]        cur_n;
  logic              buf_v;
  logic [LANES-1:0]  sd_q, unit_w;
  logic              unit_ok_q;
  logic [CNT_W-1:0]  units_q, bytes_q, bytes_init;
  logic [CNT_W:0]    sum_w;
  logic              accept, need, have_cur, can_load;

  assign sum_w      = {1'b0, cycles_i} + (init_quad_i ? (CNT_W+1)'(1) : (CNT_W+1)'(7));
  assign bytes_init = init_quad_i ? sum_w[CNT_W:1] : CNT_W'(sum_w >> 3);

  assign ready_o  = busy_i && !buf_v && (bytes_q != '0);
  assign accept   = valid_i && ready_o;
  assign need     = busy_i && (!unit_ok_q || take_i);
  assign have_cur = (cur_n != 4'd0);
  assign can_load = need && (units_q != '0) && (have_cur || buf_v);
  assign src_w    = have_cur ? cur_q : buf_q;
  assign src_shift = quad_i ? (src_w << LANES) : (src_w << 1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_lsb
      assign unit_w[i] = quad_i ? src_w[BYTE_W-LANES+i] : src_w[BYTE_W-1];
    end else begin : g_upper
      assign unit_w[i] = quad_i & src_w[BYTE_W-LANES+i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      cur_n     <= '0;
      buf_q     <= '0;
      buf_v     <= 1'b0;
      sd_q      <= '0;
      unit_ok_q <= 1'b0;
      units_q   <= '0;
      bytes_q   <= '0;
    end else if (restart_i) begin
      cur_n     <= '0;
      buf_v     <= 1'b0;
      sd_q      <= '0;
      unit_ok_q <= 1'b0;
      units_q   <= cycles_i;
      bytes_q   <= bytes_init;
    end else begin
      if (accept) begin
        buf_q   <= data_i;
        buf_v   <= 1'b1;
        bytes_q <= bytes_q - CNT_W'(1);
      end
      if (can_load) begin
        sd_q      <= unit_w;
        unit_ok_q <= 1'b1;
        units_q   <= units_q - CNT_W'(1);
        cur_q     <= src_shift;
        if (have_cur) begin
          cur_n <= cur_n - 4'd1;
        end else begin
          cur_n <= quad_i ? 4'd1 : 4'd7;
          buf_v <= 1'b0;
        end
      end else if (need) begin
        unit_ok_q <= 1'b0;
        if (take_i && units_q == '0) sd_q <= '0;
      end
    end
  end

  assign sd_o      = sd_q;
  assign unit_ok_o = unit_ok_q;

  assert_sd_steady_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> $stable(sd_q));
endmodule

// File: rtl/spi_burst_tx.sv
module spi_burst_tx
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PH_W  = 4,
  parameter int unsigned DIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              quad_i,
  input  logic [DIV_W-1:0]  div_sel_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sck_o,
  output logic [LANES-1:0]  sd_o,
  output logic              done_o
);
  logic             restart, busy, run, fin, take, unit_ok, quad_l;
  logic [DIV_W-1:0] div_l;

  spi_burst_ctrl #(.CNT_W(CNT_W), .PH_W(PH_W), .DIV_W(DIV_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .quad_i, .div_sel_i, .phase_i, .cycles_i,
    .fin_i(fin), .restart_o(restart), .busy_o(busy), .run_o(run),
    .done_o, .quad_o(quad_l), .div_sel_o(div_l)
  );

  spi_burst_clkgen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .restart_i(restart), .en_i(run), .div_sel_i(div_l),
    .cycles_i, .unit_ok_i(unit_ok), .sck_o, .take_o(take), .fin_o(fin)
  );

  spi_burst_shifter #(.CNT_W(CNT_W)) u_shifter (
    .clk_i, .rst_ni, .restart_i(restart), .init_quad_i(quad_i), .cycles_i,
    .busy_i(busy), .quad_i(quad_l), .take_i(take), .sck_i(sck_o),
    .data_i, .valid_i, .ready_o, .sd_o, .unit_ok_o(unit_ok)
  );
endmodule

// File: tb/tb_spi_burst_tx.sv
module tb_spi_burst_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, quad_i = 1'b0, valid_i = 1'b0;
  logic [1:0]  div_sel_i = '0;
  logic [3:0]  phase_i = '0;
  logic [15:0] cycles_i = '0;
  logic [7:0]  data_i = '0;
  logic        ready_o, sck_o, done_o;
  logic [3:0]  sd_o;

  always #4 clk = ~clk;

  spi_burst_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .quad_i, .div_sel_i, .phase_i,
    .cycles_i, .data_i, .valid_i, .ready_o, .sck_o, .sd_o, .done_o
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] stim_q[$];
  logic [7:0] exp_q[$];
  string tag = "";
  bit    quad_m = 0, gap_en = 0, first_pend = 0, burst_done = 0;
  int    exp_cycles = 0, exp_half = 0, exp_lead = 0, t_start = 0, pulses = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (%s)", req, act, exp, tag);
    end
  endtask

  // stream feeder
  initial begin
    bit go = 0;
    int hold = 0;
    forever begin
      @(negedge clk);
      if (go) begin
        void'(stim_q.pop_front());
        if (gap_en) hold = 6;
      end
      if (hold > 0) begin
        hold--;
        valid_i = 1'b0;
      end else begin
        valid_i = (stim_q.size() > 0);
        data_i  = valid_i ? stim_q[0] : 8'h00;
      end
      go = valid_i && ready_o;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev = 0;
    int high_run = 0, nunits = 0, moved = 0;
    logic [7:0] acc = '0;
    logic [3:0] sd_rise = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sck_o && !prev) begin
          pulses++;
          sd_rise = sd_o;
          moved = 0;
          if (first_pend) begin
            chk(cyc - t_start == exp_lead, "R5 R6 first rise", cyc - t_start, exp_lead);
            first_pend = 0;
          end
          if (!quad_m) begin
            chk(sd_o[3:1] == 3'b000, "R3 idle lanes", sd_o[3:1], 0);
            acc = {acc[6:0], sd_o[0]};
          end else begin
            acc = {acc[3:0], sd_o};
          end
          nunits++;
          if (nunits == (quad_m ? 2 : 8)) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            chk(acc === e, gap_en ? "R8 byte" : (quad_m ? "R4 byte" : "R3 byte"), acc, e);
            nunits = 0;
          end
        end
        if (sck_o) begin
          high_run++;
          if (sd_o !== sd_rise) moved++;
        end else if (prev) begin
          chk(high_run == exp_half, "R1 high time", high_run, exp_half);
          chk(moved == 0, "R7 data steady", moved, 0);
          high_run = 0;
        end
        if (done_o) begin
          chk(pulses == exp_cycles, "R2 pulse count", pulses, exp_cycles);
          if (nunits > 0) begin
            int nb;
            logic [7:0] e, m, got;
            nb  = nunits * (quad_m ? 4 : 1);
            m   = 8'hFF << (8 - nb);
            got = acc << (8 - nb);
            e   = (exp_q.size() > 0) ? (exp_q.pop_front() & m) : 8'hxx;
            chk(got === e, quad_m ? "R4 partial" : "R3 partial", got, e);
            nunits = 0;
          end
          burst_done = 1;
        end
      end
      prev = sck_o;
    end
  end

  task automatic run_burst(input string t, input bit q, input int sel, input int ph,
                           input int n, input bit gaps, input int extra, input bit mid);
    int nbytes;
    tag = t;
    nbytes = q ? (n + 1) / 2 : (n + 7) / 8;
    for (int i = 0; i < nbytes + extra; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      stim_q.push_back(b);
      if (i < nbytes) exp_q.push_back(b);
    end
    @(negedge clk);
    quad_m = q; gap_en = gaps; exp_cycles = n; exp_half = sel + 1;
    exp_lead = ((ph < 2) ? 2 : ph) + sel + 1;
    pulses = 0; burst_done = 0;
    quad_i = q; div_sel_i = 2'(sel); phase_i = 4'(ph); cycles_i = 16'(n);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    t_start = cyc;
    first_pend = 1;
    if (mid) begin
      repeat (10) @(negedge clk);
      cycles_i = 16'd3; start_i = 1'b1;   // R10: must be ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!burst_done) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R9 bytes sent", exp_q.size(), 0);
    chk(stim_q.size() == extra, "R9 bytes consumed", stim_q.size(), extra);
    chk(ready_o == 1'b0, "R9 ready idle", ready_o, 0);
    chk(sck_o == 1'b0 && done_o == 1'b0, "R2 quiet after", {sck_o, done_o}, 0);
    stim_q.delete();
    gap_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "reset";
    chk(sck_o == 1'b0, "R11 sck", sck_o, 0);
    chk(sd_o == 4'h0, "R11 sd", sd_o, 0);
    chk(done_o == 1'b0, "R11 done", done_o, 0);
    chk(ready_o == 1'b0, "R11 ready", ready_o, 0);

    run_burst("single div2", 0, 0, 2, 32, 0, 1, 0);
    run_burst("quad div8", 1, 3, 5, 10, 0, 0, 0);
    run_burst("quad odd", 1, 1, 3, 7, 0, 2, 0);
    run_burst("single stall", 0, 1, 0, 20, 1, 0, 0);
    run_burst("quad stall", 1, 0, 2, 16, 1, 0, 0);
    run_burst("busy start", 0, 2, 4, 24, 0, 0, 1);
    run_burst("quad long lead", 1, 2, 15, 12, 0, 0, 0);

    begin
      int viol = 0;
      tag = "zero count";
      stim_q.push_back(8'hA5);
      @(negedge clk);
      cycles_i = '0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (sck_o || done_o || ready_o) viol++;
      end
      chk(viol == 0, "R10 zero count ignored", viol, 0);
      chk(stim_q.size() == 1, "R10 no byte taken", stim_q.size(), 1);
      stim_q.delete();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (%s)", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule